// File: doc/BRIEF.md
# Brown-Out Detector Control

This block is the digital side of a supply-monitoring brown-out detector. An analog comparator outside the block reports whether the supply has fallen under a selected threshold. The block holds the detector's configuration: enable, a two-bit threshold code, the choice between a reset response and an interrupt response, a low-power comparator mode and the enable of a separate low-voltage-reset path. It drives the threshold code, the low-power mode and the enable to the analog side. The comparator output is resynchronized into the system clock domain.

From the resynchronized comparator value the block derives a status bit and a sticky event flag. The flag records a threshold crossing in either direction. In interrupt mode the block raises an interrupt request that stays asserted until the detector is switched off. In reset mode it raises a chip reset request while the supply is under the threshold. The low-voltage-reset path is held off for a fixed settling time each time it is switched on. The settling count comes from the clock frequency.

Configuration writes arrive on a write strobe that upstream protection logic has already qualified. The event flag is cleared through a second, unprotected write strobe.

Top module: `brownout_ctl`

## Requirements
- R1: After reset, the readback byte is 0x80, meaning only bit 7 (low-voltage-reset enable) is set. In this state, thrSel is 0, irqReq and chipRstReq are 0, and lvrArmed is 0.
- R2: A cycle with cfgWe high loads five fields from wrData: bit 0 (enable), bits 2:1 (threshold code), bit 3 (1 = reset response, 0 = interrupt response), bit 5 (low-power mode) and bit 7 (low-voltage-reset enable). The same fields read back at the same positions of rdData. Bits 4 and 6 of wrData have no effect on a cfgWe write.
- R3: A write with only flagWe high never changes any configuration field.
- R4: thrSel carries the stored threshold code unchanged. Code 11 selects the highest level (4.5 V), followed by 10 (3.8 V), 01 (2.7 V) and 00 (2.2 V). lowPwr carries stored bit 5.
- R5: cmpIn (1 = supply under threshold) passes through a two-stage synchronizer. The status output, also shown in rdData bit 6, equals the synchronized value while the detector is enabled and is 0 while it is disabled. A change on cmpIn appears on the status after two clock edges.
- R6: While the detector is enabled, the event flag (rdData bit 4) is set one edge after the status would change, on both a falling and a rising crossing. While the detector is disabled, crossings do not set the flag.
- R7: A flagWe write with wrData bit 4 = 1 clears the event flag. A flagWe write with bit 4 = 0 leaves it unchanged.
- R8: In interrupt mode, irqReq rises together with the event flag. Clearing the flag does not drop irqReq. irqReq falls on the edge after the enable reads 0.
- R9: In reset mode, chipRstReq is asserted one edge after the status, while the detector is enabled and under threshold, and irqReq stays 0.
- R10: lvrArmed is 0 whenever the low-voltage-reset enable is 0. It becomes 1 a fixed number of edges (SETTLE_CYC = CLK_KHZ*SETTLE_US/1000, 20 by default) after reset release, or after a write that changes that enable from 0 to 1.
- R11: lvrRstReq is lvrTrip gated by lvrArmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Protection-qualified configuration write strobe |
| flagWe | input | 1 | Unprotected write strobe for clearing the event flag |
| wrData | input | 8 | Write data |
| cmpIn | input | 1 | Asynchronous comparator output, 1 = supply under threshold |
| lvrTrip | input | 1 | Raw trip from the low-voltage-reset circuit |
| rdData | output | 8 | Readback of configuration, flag and status |
| detEn | output | 1 | Detector enable to the analog side |
| thrSel | output | 2 | Threshold code to the analog side |
| lowPwr | output | 1 | Low-power comparator mode |
| belowThr | output | 1 | Status: enabled and under threshold |
| irqFlag | output | 1 | Sticky crossing flag |
| irqReq | output | 1 | Interrupt request |
| chipRstReq | output | 1 | Chip reset request |
| lvrArmed | output | 1 | Low-voltage-reset path settled and enabled |
| lvrRstReq | output | 1 | Gated low-voltage reset request |

## Verification
The bench targets the upward crossing. A design that detects only falling crossings leaves the flag clear when the supply recovers. It also checks that irqReq survives a flag clear: a design that ties the request to the flag drops the interrupt early. Crossings made while the detector is disabled must leave the flag clear, and a design that tracks the raw comparator reports phantom events. The settle counter is sampled one edge before and exactly at its end, after reset and after re-enable, so an off-by-one count or a missed reload shows up as an early or late arming.

// File: rtl/brownout_pkg.sv
package brownout_pkg;

  localparam int EN_BIT   = 0;
  localparam int THR_LO   = 1;
  localparam int MODE_BIT = 3;
  localparam int FLAG_BIT = 4;
  localparam int LPM_BIT  = 5;
  localparam int STAT_BIT = 6;
  localparam int LVR_BIT  = 7;

  typedef struct packed {
    logic       en;
    logic [1:0] thr;
    logic       rstMode;
    logic       lowPwr;
    logic       lvrEn;
  } bodCfg_t;

  typedef struct packed {
    logic cfgLoad;
    logic flagSet;
    logic flagClr;
    logic irqSet;
    logic irqDrop;
    logic settleLoad;
  } bodStrobe_t;

endpackage

// File: rtl/brownout_seq.sv
module brownout_seq
  import brownout_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWe,
  input  logic       flagWe,
  input  logic [7:0] wrData,
  input  logic       cmpIn,
  input  logic       curEn,
  input  logic       curRstMode,
  input  logic       curLvrEn,
  output bodStrobe_t strb,
  output bodCfg_t    newCfg,
  output logic       statusBit
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic cmpS;
  logic cmpPrev;
  logic unusedStatWr;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[0] <= 1'b0;
        else       syncQ[0] <= cmpIn;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[g] <= 1'b0;
        else       syncQ[g] <= syncQ[g-1];
      end
    end
  end

  assign cmpS = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cmpPrev <= 1'b0;
    else       cmpPrev <= cmpS;
  end

  assign unusedStatWr = wrData[STAT_BIT];
  assign statusBit    = curEn & cmpS;

  always_comb begin
    newCfg.en      = wrData[EN_BIT];
    newCfg.thr     = wrData[THR_LO +: 2];
    newCfg.rstMode = wrData[MODE_BIT];
    newCfg.lowPwr  = wrData[LPM_BIT];
    newCfg.lvrEn   = wrData[LVR_BIT];

    strb.cfgLoad    = cfgWe;
    strb.flagSet    = curEn & (cmpS ^ cmpPrev);
    strb.flagClr    = flagWe & wrData[FLAG_BIT];
    strb.irqSet     = curEn & (cmpS ^ cmpPrev) & ~curRstMode;
    strb.irqDrop    = ~curEn;
    strb.settleLoad = cfgWe & wrData[LVR_BIT] & ~curLvrEn;
  end

  AST_STATUS_TRACKS_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    curEn && $past(curEn) && $past(syncQ[SYNC_STAGES-2]) |-> statusBit); // R5

endmodule

// File: rtl/brownout_regs.sv
module brownout_regs
  import brownout_pkg::*;
#(
  parameter int SETTLE_CYC = 20,
  parameter int CNT_W      = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  bodStrobe_t strb,
  input  bodCfg_t    newCfg,
  input  logic       statusBit,
  output bodCfg_t    cfg,
  output logic       flag,
  output logic       irq,
  output logic       rstReq,
  output logic       lvrArmed
);

  logic [CNT_W-1:0] settleCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg.en      <= 1'b0;
      cfg.thr     <= 2'b00;
      cfg.rstMode <= 1'b0;
      cfg.lowPwr  <= 1'b0;
      cfg.lvrEn   <= 1'b1;
    end else if (strb.cfgLoad) begin
      cfg <= newCfg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             flag <= 1'b0;
    else if (strb.flagSet) flag <= 1'b1;
    else if (strb.flagClr) flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             irq <= 1'b0;
    else if (strb.irqDrop) irq <= 1'b0;
    else if (strb.irqSet)  irq <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rstReq <= 1'b0;
    else       rstReq <= statusBit & cfg.rstMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 settleCnt <= CNT_W'(SETTLE_CYC);
    else if (strb.settleLoad)  settleCnt <= CNT_W'(SETTLE_CYC);
    else if (settleCnt != '0)  settleCnt <= settleCnt - 1'b1;
  end

  assign lvrArmed = cfg.lvrEn & (settleCnt == '0);

  AST_FLAG_ON_CROSSING: assert property (@(posedge clk) disable iff (!rstN)
    strb.flagSet |=> flag); // R6
  AST_IRQ_PERSISTS: assert property (@(posedge clk) disable iff (!rstN)
    cfg.en && irq |=> irq); // R8
  AST_IRQ_DROPS_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.en |=> !irq); // R8
  AST_NO_RST_IN_IRQ_MODE: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.rstMode && $past(!cfg.rstMode) |-> !rstReq); // R9
  AST_SETTLE_ON_REARM: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfg.lvrEn) |-> !lvrArmed); // R10

endmodule

// File: rtl/brownout_ctl.sv
module brownout_ctl
  import brownout_pkg::*;
#(
  parameter int CLK_KHZ     = 200,
  parameter int SETTLE_US   = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWe,
  input  logic       flagWe,
  input  logic [7:0] wrData,
  input  logic       cmpIn,
  input  logic       lvrTrip,
  output logic [7:0] rdData,
  output logic       detEn,
  output logic [1:0] thrSel,
  output logic       lowPwr,
  output logic       belowThr,
  output logic       irqFlag,
  output logic       irqReq,
  output logic       chipRstReq,
  output logic       lvrArmed,
  output logic       lvrRstReq
);

  localparam int SETTLE_CYC = (CLK_KHZ * SETTLE_US) / 1000;
  localparam int CNT_W      = $clog2(SETTLE_CYC + 1);

  bodStrobe_t strb;
  bodCfg_t    cfg;
  bodCfg_t    newCfg;
  logic       statusBit;
  logic       flag;

  brownout_seq #(.SYNC_STAGES(SYNC_STAGES)) seq_i (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWe      (cfgWe),
    .flagWe     (flagWe),
    .wrData     (wrData),
    .cmpIn      (cmpIn),
    .curEn      (cfg.en),
    .curRstMode (cfg.rstMode),
    .curLvrEn   (cfg.lvrEn),
    .strb       (strb),
    .newCfg     (newCfg),
    .statusBit  (statusBit)
  );

  brownout_regs #(.SETTLE_CYC(SETTLE_CYC), .CNT_W(CNT_W)) regs_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .newCfg    (newCfg),
    .statusBit (statusBit),
    .cfg       (cfg),
    .flag      (flag),
    .irq       (irqReq),
    .rstReq    (chipRstReq),
    .lvrArmed  (lvrArmed)
  );

  assign rdData    = {cfg.lvrEn, statusBit, cfg.lowPwr, flag, cfg.rstMode, cfg.thr, cfg.en};
  assign detEn     = cfg.en;
  assign thrSel    = cfg.thr;
  assign lowPwr    = cfg.lowPwr;
  assign belowThr  = statusBit;
  assign irqFlag   = flag;
  assign lvrRstReq = lvrTrip & lvrArmed;

  AST_LVR_GATED: assert property (@(posedge clk) disable iff (!rstN)
    lvrRstReq |-> lvrArmed && lvrTrip); // R11
  AST_RST_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    chipRstReq |-> $past(belowThr)); // R9

endmodule

// File: tb/brownout_ctl_tb.sv
module brownout_ctl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 200 * 100 / 1000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWe = 1'b0, flagWe = 1'b0, cmpIn = 1'b0, lvrTrip = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       detEn, lowPwr, belowThr, irqFlag, irqReq, chipRstReq, lvrArmed, lvrRstReq;
  logic [1:0] thrSel;

  int nChk = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brownout_ctl dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .flagWe(flagWe), .wrData(wrData),
    .cmpIn(cmpIn), .lvrTrip(lvrTrip), .rdData(rdData), .detEn(detEn),
    .thrSel(thrSel), .lowPwr(lowPwr), .belowThr(belowThr), .irqFlag(irqFlag),
    .irqReq(irqReq), .chipRstReq(chipRstReq), .lvrArmed(lvrArmed), .lvrRstReq(lvrRstReq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrCfg(input logic [7:0] d);
    cfgWe = 1'b1; wrData = d; tick(1); cfgWe = 1'b0; wrData = 8'h00;
  endtask

  task automatic wrFlag(input logic [7:0] d);
    flagWe = 1'b1; wrData = d; tick(1); flagWe = 1'b0; wrData = 8'h00;
  endtask

  task automatic t_reset;
    chk("R1 readback", rdData, 8'h80);
    chk("R1 thrSel", {6'd0, thrSel}, 8'h00);
    chk("R1 irq/rst", {6'd0, irqReq, chipRstReq}, 8'h00);
    chk("R1 armed", {7'd0, lvrArmed}, 8'h00);
    tick(SETTLE - 1);
    chk("R10 not yet armed", {7'd0, lvrArmed}, 8'h00);
    tick(1);
    chk("R10 armed after reset", {7'd0, lvrArmed}, 8'h01);
  endtask

  task automatic t_cfg;
    wrCfg(8'hFF);
    chk("R2 load all", rdData, 8'hAF);
    chk("R4 thrSel 11", {6'd0, thrSel}, 8'h03);
    chk("R4 lowPwr", {7'd0, lowPwr}, 8'h01);
    wrCfg(8'h94);
    chk("R2 bit4 ignored", rdData, 8'h84);
    chk("R4 thrSel 10", {6'd0, thrSel}, 8'h02);
    wrCfg(8'h82);
    chk("R4 thrSel 01", {6'd0, thrSel}, 8'h01);
  endtask

  task automatic t_protect;
    wrFlag(8'h2F);
    chk("R3 flag write keeps cfg", rdData, 8'h82);
  endtask

  task automatic t_irq_mode;
    wrCfg(8'h81);
    tick(3);
    chk("R6 no flag on enable", {7'd0, irqFlag}, 8'h00);
    cmpIn = 1'b1;
    tick(1);
    chk("R5 one stage not enough", {7'd0, rdData[6]}, 8'h00);
    tick(1);
    chk("R5 status below", {7'd0, belowThr}, 8'h01);
    chk("R6 flag not yet", {7'd0, irqFlag}, 8'h00);
    tick(1);
    chk("R6 flag on fall", {7'd0, rdData[4]}, 8'h01);
    chk("R8 irq rises", {7'd0, irqReq}, 8'h01);
    wrFlag(8'h10);
    chk("R7 flag cleared", {7'd0, irqFlag}, 8'h00);
    chk("R8 irq survives clear", {7'd0, irqReq}, 8'h01);
    cmpIn = 1'b0;
    tick(3);
    chk("R6 flag on rise", {7'd0, irqFlag}, 8'h01);
    chk("R5 status above", {7'd0, belowThr}, 8'h00);
    wrFlag(8'h00);
    chk("R7 zero write keeps flag", {7'd0, irqFlag}, 8'h01);
    wrFlag(8'h10);
    chk("R7 flag cleared again", {7'd0, irqFlag}, 8'h00);
    wrCfg(8'h80);
    tick(1);
    chk("R8 irq dropped when disabled", {7'd0, irqReq}, 8'h00);
    cmpIn = 1'b1;
    tick(3);
    chk("R5 status 0 when disabled", {7'd0, belowThr}, 8'h00);
    chk("R6 no flag when disabled", {7'd0, irqFlag}, 8'h00);
    cmpIn = 1'b0;
    tick(3);
  endtask

  task automatic t_rst_mode;
    wrCfg(8'h89);
    cmpIn = 1'b1;
    tick(2);
    chk("R9 status first", {7'd0, belowThr}, 8'h01);
    chk("R9 rst not yet", {7'd0, chipRstReq}, 8'h00);
    tick(1);
    chk("R9 rst asserted", {7'd0, chipRstReq}, 8'h01);
    chk("R9 no irq", {7'd0, irqReq}, 8'h00);
    cmpIn = 1'b0;
    tick(3);
    chk("R9 rst released", {7'd0, chipRstReq}, 8'h00);
    cmpIn = 1'b1;
    tick(3);
    wrCfg(8'h88);
    tick(1);
    chk("R9 rst off when disabled", {7'd0, chipRstReq}, 8'h00);
    cmpIn = 1'b0;
    tick(3);
    wrFlag(8'h10);
  endtask

  task automatic t_lvr;
    wrCfg(8'h00);
    lvrTrip = 1'b1;
    #1;
    chk("R10 off when disabled", {7'd0, lvrArmed}, 8'h00);
    chk("R11 trip blocked", {7'd0, lvrRstReq}, 8'h00);
    tick(1);
    wrCfg(8'h80);
    chk("R10 reload on enable", {7'd0, lvrArmed}, 8'h00);
    tick(SETTLE - 1);
    chk("R10 one edge early", {7'd0, lvrArmed}, 8'h00);
    tick(1);
    chk("R10 armed after settle", {7'd0, lvrArmed}, 8'h01);
    chk("R11 trip passes", {7'd0, lvrRstReq}, 8'h01);
    lvrTrip = 1'b0;
    #1;
    chk("R11 no trip no request", {7'd0, lvrRstReq}, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    t_reset();
    t_cfg();
    t_protect();
    t_irq_mode();
    t_rst_mode();
    t_lvr();
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule